// File: doc/BRIEF.md
# Double-Buffered Serial Code Input Stage

This block is the digital front end of a 12-bit voltage-output converter. A host writes a code word over a three-wire serial link (data, serial clock, load strobe) plus an active-low select. Each rising serial clock edge taken while the select is low moves one bit into a staging shift register. A separate holding register receives the staged word only through the load strobe, and only the holding register drives the converter code. The two stages are separate, so a new word can be shifted in while the output stays at the previous code.

A clear input forces the holding register to zero scale, both after reset and whenever the host asserts it. The code is straight binary: each step is one half millivolt, so the all-ones code is the 2.0475 V full scale. All serial inputs are sampled by the system clock. The serial clock must therefore run well below the system clock rate.

Top module: `ser_dac_frontend`

## Requirements
- R1: After reset, `dac_code` is 0 and `code_valid` is 0. The staging register is also 0, so a load done before any shifting yields code 0.
- R2: Bits enter most significant first. After exactly 12 rising edges of `ser_clk` with `sel_n` low, followed by a load, `dac_code` equals the 12 bits in the order they were sent.
- R3: Rising edges of `ser_clk` while `sel_n` is high do not change the staging register.
- R4: When more than 12 edges arrive, the older bits fall out at the top, and the last 12 bits sent form the word.
- R5: While `load_n` is high and `clear_n` is high, `dac_code` keeps its value, even while new bits are being shifted in.
- R6: While `load_n` is low, `dac_code` follows the staging register one system clock later. When `load_n` rises, the last value is held.
- R7: While `clear_n` is low, `dac_code` becomes 0 one clock later and `code_valid` drops. Clear wins over a simultaneous low `load_n`.
- R8: `code_valid` rises on the first clock in which a load is taken. It then stays high until a clear.
- R9: The code is straight binary over the full range 0x000 to 0xFFF. Every code passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_data | input | 1 | Serial data bit |
| ser_clk | input | 1 | Serial clock; its rising edge shifts |
| sel_n | input | 1 | Active-low select that enables shifting |
| load_n | input | 1 | Active-low load strobe, level-sensitive |
| clear_n | input | 1 | Active-low clear to zero scale |
| dac_code | output | 12 | Code driven to the converter |
| code_valid | output | 1 | High once a code has been loaded since the last clear or reset |

## Verification
The bench builds the block with its defaults: 12-bit width and most-significant-first order. At that width, every one of the 4096 codes can be shifted in and loaded, and each is compared against the arithmetic value. The same loop confirms that shifting a new word leaves the held code untouched until the strobe. Directed passes then cover overlong words, edges with the select high, the following behaviour while the strobe is low, and clear taking priority over load.

// File: rtl/ser_dac_pkg.sv
package ser_dac_pkg;
   localparam int unsigned DEF_WIDTH = 12;

   typedef enum logic [1:0] {
      HOLD_KEEP  = 2'd0,
      HOLD_LOAD  = 2'd1,
      HOLD_CLEAR = 2'd2
   } hold_act_e;
endpackage

// File: rtl/ser_dac_edge.sv
module ser_dac_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_in,
   output logic rise
);
   logic sig_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sig_q <= 1'b0;
      else        sig_q <= sig_in;
   end

   assign rise = sig_in & ~sig_q;

   a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/ser_dac_shift.sv
module ser_dac_shift #(
   parameter int unsigned WIDTH     = ser_dac_pkg::DEF_WIDTH,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_en,
   input  logic             din,
   output logic [WIDTH-1:0] word
);
   localparam int unsigned TOP = WIDTH - 1;

   initial begin
      assert (WIDTH >= 2 && WIDTH <= 32)
         else $error("ser_dac_shift: WIDTH out of range");
   end

   logic [WIDTH-1:0] nxt;

   generate
      if (MSB_FIRST) begin : g_msb
         assign nxt = {word[TOP-1:0], din};
      end else begin : g_lsb
         assign nxt = {din, word[TOP:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        word <= '0;
      else if (shift_en) word <= nxt;
   end

   a_r3_no_shift_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(word));
endmodule

// File: rtl/ser_dac_hold.sv
module ser_dac_hold #(
   parameter int unsigned WIDTH = ser_dac_pkg::DEF_WIDTH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_n,
   input  logic             clear_n,
   input  logic [WIDTH-1:0] staged,
   output logic [WIDTH-1:0] code,
   output logic             valid
);
   import ser_dac_pkg::*;

   hold_act_e act;

   always_comb begin
      if (!clear_n)     act = HOLD_CLEAR;
      else if (!load_n) act = HOLD_LOAD;
      else              act = HOLD_KEEP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code  <= '0;
         valid <= 1'b0;
      end else begin
         case (act)
            HOLD_CLEAR: begin
               code  <= '0;
               valid <= 1'b0;
            end
            HOLD_LOAD: begin
               code  <= staged;
               valid <= 1'b1;
            end
            default: ;
         endcase
      end
   end

   a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !clear_n |=> (code == '0) && !valid);
   a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && clear_n) |=> $stable(code) && $stable(valid));
   a_r6_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_n && clear_n) |=> (code == $past(staged)));
   a_r8_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && clear_n) |=> valid);
endmodule

// File: rtl/ser_dac_frontend.sv
module ser_dac_frontend #(
   parameter int unsigned WIDTH     = ser_dac_pkg::DEF_WIDTH,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ser_data,
   input  logic             ser_clk,
   input  logic             sel_n,
   input  logic             load_n,
   input  logic             clear_n,
   output logic [WIDTH-1:0] dac_code,
   output logic             code_valid
);
   logic             sclk_rise;
   logic             shift_en;
   logic [WIDTH-1:0] staged;

   ser_dac_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .sig_in (ser_clk),
      .rise   (sclk_rise)
   );

   assign shift_en = sclk_rise & ~sel_n;

   ser_dac_shift #(.WIDTH(WIDTH), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_en),
      .din      (ser_data),
      .word     (staged)
   );

   ser_dac_hold #(.WIDTH(WIDTH)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_n  (load_n),
      .clear_n (clear_n),
      .staged  (staged),
      .code    (dac_code),
      .valid   (code_valid)
   );

   a_r3_select_gates: assert property (@(posedge clk) disable iff (!rst_n)
      sel_n |=> $stable(staged));
endmodule

// File: tb/ser_dac_frontend_test.sv
module ser_dac_frontend_test;
   localparam int W = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_data = 1'b0, ser_clk = 1'b0, sel_n = 1'b1;
   logic load_n = 1'b1, clear_n = 1'b1;
   logic [W-1:0] dac_code;
   logic code_valid;

   int total = 0;
   int bad = 0;
   bit finished = 0;
   logic [W-1:0] exp_shift = '0;

   always #5 clk = ~clk;

   ser_dac_frontend uut (
      .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
      .sel_n(sel_n), .load_n(load_n), .clear_n(clear_n),
      .dac_code(dac_code), .code_valid(code_valid)
   );

   task automatic check(input string req, input int got, input int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic send_bit(input logic b, input logic sel);
      @(negedge clk);
      ser_clk = 1'b0; ser_data = b; sel_n = sel;
      @(negedge clk);
      ser_clk = 1'b1;
      @(negedge clk);
      ser_clk = 1'b0;
      if (!sel) exp_shift = {exp_shift[W-2:0], b};
   endtask

   task automatic send_word(input logic [31:0] v, input int n, input logic sel);
      for (int i = n - 1; i >= 0; i--) send_bit(v[i], sel);
      @(negedge clk);
      sel_n = 1'b1;
   endtask

   task automatic do_load();
      @(negedge clk); load_n = 1'b0;
      @(negedge clk);
      @(negedge clk); load_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      #(1_900_000ns);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: got 0x0 expected 0x1");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] held;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 code", dac_code, 0);
      check("R1 valid", code_valid, 0);
      do_load();
      check("R1 staged zero", dac_code, 0);
      check("R8 valid after load", code_valid, 1);

      // R2 / R9 / R5 exhaustive sweep
      held = '0;
      for (int c = 0; c < (1 << W); c++) begin
         send_word(c, W, 1'b0);
         check("R5 held during shift", dac_code, held);
         do_load();
         check("R2 R9 code", dac_code, c);
         held = c[W-1:0];
      end

      // R4 overlong word: 15 bits, last 12 win
      send_word(32'h5A3C, 15, 1'b0);
      do_load();
      check("R4 last bits win", dac_code, 32'h5A3C & 32'hFFF);
      check("R4 model", dac_code, exp_shift);

      // R3 select high blocks shifting
      send_word(32'h9C1, W, 1'b0);
      send_word(32'h2B7, W, 1'b1);
      do_load();
      check("R3 select high ignored", dac_code, 32'h9C1);

      // R6 follow while load low
      @(negedge clk); load_n = 1'b0;
      send_bit(1'b1, 1'b0);
      @(negedge clk);
      check("R6 follows staged", dac_code, exp_shift);
      send_bit(1'b0, 1'b0);
      @(negedge clk);
      check("R6 follows again", dac_code, exp_shift);
      load_n = 1'b1;
      held = exp_shift;
      send_word(32'hFFF, W, 1'b0);
      check("R6 held after rise", dac_code, held);

      // R7 clear, with priority over load
      @(negedge clk); clear_n = 1'b0; load_n = 1'b0;
      @(negedge clk);
      check("R7 clear zero", dac_code, 0);
      check("R7 clear valid", code_valid, 0);
      @(negedge clk);
      check("R7 clear beats load", dac_code, 0);
      load_n = 1'b1;
      @(negedge clk); clear_n = 1'b1;
      @(negedge clk);
      check("R8 valid stays low", code_valid, 0);
      check("R7 code stays zero", dac_code, 0);
      do_load();
      check("R8 valid after reload", code_valid, 1);
      check("R2 reload full scale", dac_code, 32'hFFF);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule